// File: doc/BRIEF.md
# Instruction Exception Classifier with Delay-Slot Tracking

This block sits next to an instruction decoder and turns the class flags of each decoded instruction into an instruction exception decision. The decoder supplies one flag for each class:

- trap
- undefined opcode
- delayed branch
- PC-rewriting
- 32-bit length
- FPU-related
- bank-restore
- divide step

The block keeps one bit of state that records whether the next instruction sits in the slot directly behind a delayed branch. A fixed three-level priority then chooses between a trap, a general illegal instruction and a slot illegal instruction.

Several instruction classes are legal in normal flow but illegal in a delay slot. In a slot, these all raise slot illegal:

- anything that rewrites the PC, including the trap instruction and the other delayed branches
- undefined code
- any 32-bit instruction
- bank restore and divide steps
- FPU-related work while the FPU is in standby

A classified exception is held in a single pending register until the previous instruction reports completion. It is then issued as a one-cycle request with a registered code. While an exception waits, further decoded instructions are ignored, because they belong to a flow that is about to be abandoned.

Top module: `insn_exc_classifier`

## Requirements
- R1: In the cycle after reset is sampled high, `exc_req` is 0, `exc_code` is 2'b00 and `in_slot` is 0.
- R2: An accepted instruction flagged as trap, outside a delay slot, yields exception code 2'b01. This holds even if the undefined flag is also set, because trap outranks general illegal.
- R3: An accepted undefined instruction outside a delay slot, with no trap flag, yields code 2'b10 (general illegal).
- R4: An accepted delayed branch that raises no exception sets `in_slot` on the next cycle. `in_slot` holds through idle cycles and clears after exactly one further accepted instruction. Reset also clears it.
- R5: In a delay slot, an accepted instruction flagged as undefined, PC-rewriting, delayed branch, trap, 32-bit, bank-restore or divide yields code 2'b11 (slot illegal).
- R6: An FPU-related instruction in a delay slot yields 2'b11 only while `fpu_standby` is 1. Otherwise it raises nothing. Outside a slot it never raises an exception.
- R7: `exc_req` goes high for one cycle, in the cycle after the clock edge at which an exception is pending or newly classified and `prev_done` is 1. `exc_code` is 2'b00 whenever `exc_req` is 0.
- R8: Classifying an exception clears `in_slot`. While an exception is pending, decoded instructions are ignored and do not change the code issued later.
- R9: In a delay slot, an instruction with none of the slot-illegal flags raises no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decoded instruction is presented this cycle |
| dec_trap | input | 1 | Instruction is the trap instruction |
| dec_undef | input | 1 | Opcode is undefined |
| dec_dbranch | input | 1 | Instruction is a delayed branch |
| dec_pcwr | input | 1 | Instruction rewrites the PC |
| dec_long | input | 1 | Instruction is 32 bits long |
| dec_fpu | input | 1 | Instruction is FPU or FPU-related |
| dec_bank | input | 1 | Instruction is the bank-restore instruction |
| dec_div | input | 1 | Instruction is a signed or unsigned divide step |
| fpu_standby | input | 1 | FPU module is in standby |
| prev_done | input | 1 | Previously executing instruction has finished |
| exc_req | output | 1 | One-cycle exception request |
| exc_code | output | 2 | 00 none, 01 trap, 10 general illegal, 11 slot illegal |
| in_slot | output | 1 | Next accepted instruction occupies a delay slot |

## Verification
Flags are classified against the slot state at the rising edge where `dec_valid` is sampled. `in_slot` is updated at that same edge. The request and code appear one edge after the edge where `prev_done` is seen high with an exception pending or newly classified, which is the same edge when `prev_done` is already high.

The bench therefore drives inputs at the falling edge. It compares outputs at the next falling edge when `prev_done` is held high. In the hold tests, where `prev_done` is low, it compares one falling edge after `prev_done` is raised.

// File: rtl/insn_exc_pkg.sv
package insn_exc_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    EXC_NONE    = 2'b00,
    EXC_TRAP    = 2'b01,
    EXC_ILLEGAL = 2'b10,
    EXC_SLOT    = 2'b11
  } exc_code_e;

  typedef struct packed {
    logic trap;
    logic undef;
    logic dbranch;
    logic pcwr;
    logic long32;
    logic fpu;
    logic bank;
    logic div;
  } insn_class_t;
endpackage

// File: rtl/exc_slot_tracker.sv
module exc_slot_tracker (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic is_dbranch,
  input  logic raise,
  output logic in_slot
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_slot <= 1'b0;
    end else if (accept) begin
      // one accepted instruction consumes the slot; a clean delayed branch opens a new one
      in_slot <= is_dbranch && !raise;
    end
  end
endmodule

// File: rtl/exc_prioritizer.sv
module exc_prioritizer
  import insn_exc_pkg::*;
#(
  parameter bit FPU_SLOT_RULE = 1'b1
) (
  input  insn_class_t cls,
  input  logic        in_slot,
  input  logic        fpu_standby,
  output exc_code_e   code
);
  logic fpu_bad;
  logic slot_bad;

  generate
    if (FPU_SLOT_RULE) begin : g_fpu_rule
      assign fpu_bad = cls.fpu && fpu_standby;
    end else begin : g_no_fpu_rule
      assign fpu_bad = 1'b0;
    end
  endgenerate

  always_comb begin
    slot_bad = in_slot && (cls.undef || cls.pcwr || cls.dbranch || cls.trap ||
                           cls.long32 || cls.bank || cls.div || fpu_bad);
    if (slot_bad)       code = EXC_SLOT;
    else if (cls.trap)  code = EXC_TRAP;
    else if (cls.undef) code = EXC_ILLEGAL;
    else                code = EXC_NONE;
  end
endmodule

// File: rtl/exc_issue_stage.sv
module exc_issue_stage
  import insn_exc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                raise,
  input  exc_code_e           new_code,
  input  logic                prev_done,
  output logic                busy,
  output logic                exc_req,
  output logic [CODE_W-1:0]   exc_code
);
  exc_code_e held_code;
  exc_code_e fire_code;
  logic      fire;

  always_comb begin
    fire      = (busy || raise) && prev_done;
    fire_code = busy ? held_code : new_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      held_code <= EXC_NONE;
      exc_req   <= 1'b0;
      exc_code  <= '0;
    end else begin
      exc_req  <= fire;
      exc_code <= fire ? fire_code : '0;
      if (fire) begin
        busy <= 1'b0;
      end else if (raise) begin
        busy      <= 1'b1;
        held_code <= new_code;
      end
    end
  end
endmodule

// File: rtl/insn_exc_classifier.sv
module insn_exc_classifier
  import insn_exc_pkg::*;
#(
  parameter bit FPU_SLOT_RULE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_valid,
  input  logic              dec_trap,
  input  logic              dec_undef,
  input  logic              dec_dbranch,
  input  logic              dec_pcwr,
  input  logic              dec_long,
  input  logic              dec_fpu,
  input  logic              dec_bank,
  input  logic              dec_div,
  input  logic              fpu_standby,
  input  logic              prev_done,
  output logic              exc_req,
  output logic [CODE_W-1:0] exc_code,
  output logic              in_slot
);
  insn_class_t cls;
  exc_code_e   cls_code;
  logic        busy;
  logic        accept;
  logic        raise;

  assign cls = '{trap: dec_trap, undef: dec_undef, dbranch: dec_dbranch,
                 pcwr: dec_pcwr, long32: dec_long, fpu: dec_fpu,
                 bank: dec_bank, div: dec_div};

  assign accept = dec_valid && !busy;
  assign raise  = accept && (cls_code != EXC_NONE);

  exc_slot_tracker u_slot (
    .clk(clk), .rst(rst), .accept(accept), .is_dbranch(dec_dbranch),
    .raise(raise), .in_slot(in_slot)
  );

  exc_prioritizer #(.FPU_SLOT_RULE(FPU_SLOT_RULE)) u_prio (
    .cls(cls), .in_slot(in_slot), .fpu_standby(fpu_standby), .code(cls_code)
  );

  exc_issue_stage u_issue (
    .clk(clk), .rst(rst), .raise(raise), .new_code(cls_code),
    .prev_done(prev_done), .busy(busy), .exc_req(exc_req), .exc_code(exc_code)
  );
endmodule

// File: rtl/insn_exc_classifier_chk.sv
module insn_exc_classifier_chk (
  input logic       clk,
  input logic       rst,
  input logic       dec_valid,
  input logic       dec_trap,
  input logic       dec_undef,
  input logic       dec_dbranch,
  input logic       prev_done,
  input logic       busy,
  input logic       exc_req,
  input logic [1:0] exc_code,
  input logic       in_slot
);
  // R7
  code_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !exc_req |-> exc_code == 2'b00);
  // R7
  req_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> $past(prev_done));
  // R4
  slot_from_branch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_slot) |-> $past(dec_valid && dec_dbranch));
  // R8
  req_no_slot_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> !in_slot);
  // R2
  trap_code_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !busy && dec_trap && !in_slot && prev_done |=> exc_req && exc_code == 2'b01);
  // R5
  slot_undef_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !busy && dec_undef && in_slot && prev_done |=> exc_req && exc_code == 2'b11);
endmodule

bind insn_exc_classifier insn_exc_classifier_chk u_chk (
  .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_trap(dec_trap),
  .dec_undef(dec_undef), .dec_dbranch(dec_dbranch), .prev_done(prev_done),
  .busy(busy), .exc_req(exc_req), .exc_code(exc_code), .in_slot(in_slot)
);

// File: tb/insn_exc_classifier_tb.sv
module insn_exc_classifier_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 1'b0, dec_trap = 1'b0, dec_undef = 1'b0, dec_dbranch = 1'b0;
  logic dec_pcwr = 1'b0, dec_long = 1'b0, dec_fpu = 1'b0, dec_bank = 1'b0, dec_div = 1'b0;
  logic fpu_standby = 1'b0, prev_done = 1'b0;
  logic exc_req;
  logic [1:0] exc_code;
  logic in_slot;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  insn_exc_classifier u_dut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_trap(dec_trap),
    .dec_undef(dec_undef), .dec_dbranch(dec_dbranch), .dec_pcwr(dec_pcwr),
    .dec_long(dec_long), .dec_fpu(dec_fpu), .dec_bank(dec_bank), .dec_div(dec_div),
    .fpu_standby(fpu_standby), .prev_done(prev_done),
    .exc_req(exc_req), .exc_code(exc_code), .in_slot(in_slot)
  );

  // {valid, trap undef dbr pcwr long fpu bank div, standby done, exp_req exp_code exp_slot}
  localparam int NV = 27;
  localparam logic [14:0] VEC [0:NV-1] = '{
    15'b1_00000000_01_0000, // R9 plain
    15'b1_10000000_01_1010, // R2 trap
    15'b1_01000000_01_1100, // R3 undefined
    15'b1_11000000_01_1010, // R2 trap beats undefined
    15'b1_00110000_01_0001, // R4 delayed branch
    15'b1_00000000_01_0000, // R9 plain in slot, slot closes
    15'b1_00110000_01_0001,
    15'b1_01000000_01_1110, // R5 undefined in slot
    15'b1_00110000_01_0001,
    15'b1_00010000_01_1110, // R5 pc rewrite in slot
    15'b1_00110000_01_0001,
    15'b1_10010000_01_1110, // R5 trap in slot
    15'b1_00110000_01_0001,
    15'b1_00001000_01_1110, // R5 32-bit in slot
    15'b1_00110000_01_0001,
    15'b1_00000010_01_1110, // R5 bank restore in slot
    15'b1_00110000_01_0001,
    15'b1_00000001_01_1110, // R5 divide in slot
    15'b1_00110000_01_0001,
    15'b1_00000100_01_0000, // R6 fpu in slot, active
    15'b1_00110000_01_0001,
    15'b1_00000100_11_1110, // R6 fpu in slot, standby
    15'b1_00110000_01_0001,
    15'b1_00110000_01_1110, // R5 branch in slot
    15'b1_00001000_01_0000, // R9 32-bit outside slot
    15'b1_00000100_11_0000, // R6 fpu outside slot
    15'b1_00000010_01_0000  // R9 bank restore outside slot
  };

  function automatic string vtag(logic [14:0] v);
    if (v[3:1] == 3'b101) return "R2";
    if (v[3:1] == 3'b110) return "R3";
    if (v[3:1] == 3'b111) return v[8] ? "R6" : "R5";
    if (v[0]) return "R4";
    if (v[8]) return "R6";
    return "R9";
  endfunction

  task automatic check(string tag, logic er, logic [1:0] ec, logic es);
    checks++;
    if (exc_req !== er || exc_code !== ec || in_slot !== es) begin
      errors++;
      $display("FAIL %s: req/code/slot got %b/%b/%b expected %b/%b/%b",
               tag, exc_req, exc_code, in_slot, er, ec, es);
    end
  endtask

  task automatic drive(logic [10:0] d);
    {dec_valid, dec_trap, dec_undef, dec_dbranch, dec_pcwr, dec_long,
     dec_fpu, dec_bank, dec_div, fpu_standby, prev_done} = d;
  endtask

  initial begin
    #200000;
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", 1'b0, 2'b00, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14:4]);
      @(negedge clk);
      check(vtag(VEC[i]), VEC[i][3], VEC[i][2:1], VEC[i][0]);
    end

    // R7: trap held while previous instruction still running
    drive(11'b1_10000000_00);
    @(negedge clk);
    check("R7", 1'b0, 2'b00, 1'b0);
    // R8: undefined presented while pending is ignored
    drive(11'b1_01000000_00);
    @(negedge clk);
    check("R8", 1'b0, 2'b00, 1'b0);
    drive(11'b0_00000000_01);
    @(negedge clk);
    check("R7", 1'b1, 2'b01, 1'b0);
    drive(11'b0_00000000_00);
    @(negedge clk);
    check("R7", 1'b0, 2'b00, 1'b0);

    // R8: slot exception clears slot at once, issues later
    drive(11'b1_00110000_00);
    @(negedge clk);
    check("R4", 1'b0, 2'b00, 1'b1);
    drive(11'b0_00000000_00);
    @(negedge clk);
    check("R4", 1'b0, 2'b00, 1'b1);
    drive(11'b1_01000000_00);
    @(negedge clk);
    check("R8", 1'b0, 2'b00, 1'b0);
    drive(11'b0_00000000_01);
    @(negedge clk);
    check("R8", 1'b1, 2'b11, 1'b0);
    drive(11'b1_01000000_01);
    @(negedge clk);
    check("R3", 1'b1, 2'b10, 1'b0);

    // R4: reset closes an open slot
    drive(11'b1_00110000_01);
    @(negedge clk);
    check("R4", 1'b0, 2'b00, 1'b1);
    drive(11'b0_00000000_00);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 2'b00, 1'b0);
    rst = 1'b0;
    drive(11'b1_01000000_01);
    @(negedge clk);
    check("R4", 1'b1, 2'b10, 1'b0);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule